// File: doc/BRIEF.md
# Double-Buffered Serial Output Shifter

This block drives a serial data pin and a matching serial clock from two 16-bit holding buffers. The controlling core keeps a 32-bit output word in the block and copies its low 16 bits into either holding buffer with a one-cycle strobe. A buffer that has been filled and not yet sent is marked fresh. When shifting is enabled, the block moves a fresh buffer into its shift register and sends it least significant bit first, one bit per serial clock period. Each serial clock period is two core clock cycles.

Draining continues in every output mode. The data pin and the serial clock are only driven in serial mode, so in any other mode the buffer empties without a visible trace. Lowering the enable does not cut a word short. The drain in progress runs to its last bit, and no new word is started after it. If the selected buffer has nothing fresh and the other one does, the block sends the other one. This lets the core refill one buffer while the other is being sent.

The serial data pin changes on the falling edge of the serial clock and is stable on its rising edge. Between two words the data pin rests at 0 for one serial clock period.

Top module: `serout_dbuf`

## Requirements
- R1: After reset the serial data pin, serial clock, busy flag and output word are all 0.
- R2: A write pulse stores the 32-bit write data as the output word, and this word holds its value across any change of output mode.
- R3: A load strobe copies bits 15:0 of the current output word into the matching holding buffer (strobe 0 to buffer 0, strobe 1 to buffer 1) in any output mode, and marks that buffer fresh.
- R4: A word is sent least significant bit first. On the 16 successive rising edges of the serial clock that follow the one on which the data pin still rests, the pin carries bits 0 through 15 of the buffer.
- R5: When a drain may start and the buffer named by the select input is fresh, that buffer is sent and stops being fresh.
- R6: When a drain may start, the selected buffer is not fresh and the other buffer is, the other buffer is sent. With neither buffer fresh the block stays idle.
- R7: A drain starts only while the shift enable is high. Lowering the enable during a drain lets that word finish, and no further word starts.
- R8: With mode encoding 2'b01 denoting serial mode, in any other mode a drain still empties the buffer but the data pin stays 0.
- R9: In serial mode the serial clock toggles every core cycle, whether or not shifting is enabled. In any other mode it is 0.
- R10: Busy is high for exactly 32 core cycles per word (16 serial periods), and the data pin returns to 0 one serial period after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Output mode; 2'b01 is serial mode, all other codes are non-serial |
| wr_en_i | input | 1 | Write pulse for the output word |
| wr_data_i | input | 32 | New output word value |
| ld_buf0_i | input | 1 | Copy output word bits 15:0 into buffer 0 |
| ld_buf1_i | input | 1 | Copy output word bits 15:0 into buffer 1 |
| buf_sel_i | input | 1 | Preferred buffer for the next drain |
| shift_en_i | input | 1 | Shift enable |
| out_word_o | output | 32 | Current output word |
| ser_data_o | output | 1 | Serial data pin |
| ser_clk_o | output | 1 | Serial clock pin |
| busy_o | output | 1 | High while a word is being drained |

## Verification
Four things are checked on every cycle. The serial clock stays parked outside serial mode and toggles inside it. The data pin stays 0 outside serial mode. Busy can only rise after the enable was high. Every drain lasts exactly 32 cycles, which a counter in the checker measures. The bench scenarios cover the rest: the bit order of each word, the choice of buffer when both or only one are fresh, a drain started under a lowered enable finishing its word, a buffer emptied silently in a non-serial mode, and the output word surviving mode changes.

// File: rtl/serout_pkg.sv
package serout_pkg;
  localparam logic [1:0] MODE_SERIAL = 2'b01;

  function automatic logic is_serial(input logic [1:0] m);
    return m == MODE_SERIAL;
  endfunction
endpackage

// File: rtl/serout_buf_bank.sv
module serout_buf_bank #(
  parameter int BUF_W = 16,
  parameter int N_BUF = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_BUF-1:0]            load,
  input  logic [BUF_W-1:0]            fill,
  input  logic                        take,
  input  logic [$clog2(N_BUF)-1:0]    take_idx,
  output logic [N_BUF-1:0][BUF_W-1:0] data,
  output logic [N_BUF-1:0]            fresh
);
  localparam int IDX_W = $clog2(N_BUF);

  for (genvar k = 0; k < N_BUF; k++) begin : g_buf
    // a load in the same cycle as a take wins: the new content stays pending
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data[k]  <= '0;
        fresh[k] <= 1'b0;
      end else if (load[k]) begin
        data[k]  <= fill;
        fresh[k] <= 1'b1;
      end else if (take && take_idx == IDX_W'(k)) begin
        fresh[k] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serout_drain.sv
module serout_drain #(
  parameter int BUF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  sel,
  input  logic [1:0]            fresh,
  input  logic [1:0][BUF_W-1:0] bufs,
  output logic                  take,
  output logic                  take_idx,
  output logic                  step,
  output logic                  phase,
  output logic                  bit_val,
  output logic                  busy
);
  localparam int CNT_W = $clog2(BUF_W + 1);

  logic             ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BUF_W-1:0] sr_q;
  logic             pick;
  logic             can_start;

  // prefer the selected buffer, fall back to the other one
  assign pick      = fresh[sel] ? sel : ~sel;
  assign can_start = ph_q && (cnt_q == '0) && enable && (fresh != 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      ph_q <= ~ph_q;
      if (can_start) begin
        sr_q  <= bufs[pick];
        cnt_q <= CNT_W'(BUF_W);
      end else if (ph_q && cnt_q != '0) begin
        sr_q  <= {1'b0, sr_q[BUF_W-1:1]};
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign take     = can_start;
  assign take_idx = pick;
  assign step     = ph_q;
  assign phase    = ph_q;
  assign bit_val  = (cnt_q != '0) && sr_q[0];
  assign busy     = cnt_q != '0;
endmodule

// File: rtl/serout_pins.sv
module serout_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic serial_mode,
  input  logic step,
  input  logic phase,
  input  logic bit_val,
  output logic ser_data,
  output logic ser_clk
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_data <= 1'b0;
      ser_clk  <= 1'b0;
    end else begin
      ser_clk <= serial_mode & ~phase;
      if (!serial_mode)
        ser_data <= 1'b0;
      else if (step)
        ser_data <= bit_val;
    end
  end
endmodule

// File: rtl/serout_dbuf.sv
module serout_dbuf
  import serout_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BUF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              ld_buf0_i,
  input  logic              ld_buf1_i,
  input  logic              buf_sel_i,
  input  logic              shift_en_i,
  output logic [WORD_W-1:0] out_word_o,
  output logic              ser_data_o,
  output logic              ser_clk_o,
  output logic              busy_o
);
  logic [WORD_W-1:0]     word_q;
  logic [1:0][BUF_W-1:0] bufs;
  logic [1:0]            fresh;
  logic                  take, take_idx, step, phase, bit_val;

  always_ff @(posedge clk) begin
    if (!rst_n)       word_q <= '0;
    else if (wr_en_i) word_q <= wr_data_i;
  end
  assign out_word_o = word_q;

  serout_buf_bank #(.BUF_W(BUF_W), .N_BUF(2)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .load({ld_buf1_i, ld_buf0_i}), .fill(word_q[BUF_W-1:0]),
    .take(take), .take_idx(take_idx),
    .data(bufs), .fresh(fresh)
  );

  serout_drain #(.BUF_W(BUF_W)) u_drain (
    .clk(clk), .rst_n(rst_n),
    .enable(shift_en_i), .sel(buf_sel_i),
    .fresh(fresh), .bufs(bufs),
    .take(take), .take_idx(take_idx),
    .step(step), .phase(phase), .bit_val(bit_val), .busy(busy_o)
  );

  serout_pins u_pins (
    .clk(clk), .rst_n(rst_n),
    .serial_mode(is_serial(mode_i)),
    .step(step), .phase(phase), .bit_val(bit_val),
    .ser_data(ser_data_o), .ser_clk(ser_clk_o)
  );
endmodule

// File: rtl/serout_dbuf_chk.sv
module serout_dbuf_chk #(
  parameter int BUF_W = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       shift_en_i,
  input logic       ser_data_o,
  input logic       ser_clk_o,
  input logic       busy_o
);
  localparam int RUN_W = $clog2(2 * BUF_W + 2);

  logic [RUN_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + RUN_W'(1);
    else             run_q <= '0;
  end

  AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i) != 2'b01 |-> !ser_clk_o);  // R9

  AST_CLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_i) == 2'b01 && $past(mode_i, 2) == 2'b01 && $past(rst_n, 2))
      |-> ser_clk_o != $past(ser_clk_o));  // R9

  AST_DATA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_i) != 2'b01 |-> !ser_data_o);  // R8

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(shift_en_i));  // R7

  AST_DRAIN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> run_q == RUN_W'(2 * BUF_W));  // R10
endmodule

bind serout_dbuf serout_dbuf_chk #(.BUF_W(BUF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .shift_en_i(shift_en_i),
  .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o), .busy_o(busy_o)
);

// File: tb/serout_dbuf_test.sv
module serout_dbuf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        ld_buf0_i = 1'b0, ld_buf1_i = 1'b0;
  logic        buf_sel_i = 1'b0, shift_en_i = 1'b0;
  logic [31:0] out_word_o;
  logic        ser_data_o, ser_clk_o, busy_o;

  int checks = 0;
  int errors = 0;

  serout_dbuf uut (.*);

  always #2 clk = ~clk;

  function automatic logic [15:0] expect_stream(input logic [31:0] w);
    return w[15:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = w;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic load_buf(input logic [31:0] w, input bit idx);
    write_word(w);
    if (idx) ld_buf1_i = 1'b1; else ld_buf0_i = 1'b0 | 1'b1;
    @(negedge clk); ld_buf0_i = 1'b0; ld_buf1_i = 1'b0;
  endtask

  // waits for a drain to start, then samples the pin on the 17 following rising serial clocks
  task automatic collect(input bit drop_en, output logic [15:0] got, output bit started);
    bit prev;
    int n;
    got = '0; started = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (busy_o) begin started = 1; break; end
    end
    if (!started) return;
    if (drop_en) shift_en_i = 1'b0;
    prev = ser_clk_o; n = 0;
    for (int i = 0; i < 200 && n < 17; i++) begin
      @(negedge clk);
      if (ser_clk_o && !prev) begin
        if (n > 0) got[n-1] = ser_data_o;
        n++;
      end
      prev = ser_clk_o;
    end
  endtask

  task automatic stay_idle(input int cyc, input string tag);
    bit quiet = 1;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (busy_o || ser_data_o) quiet = 0;
    end
    check(quiet, tag, {30'd0, busy_o, ser_data_o}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] got;
    bit started;
    logic [31:0] a, b;
    int run;
    bit toggling, parked, silent;
    void'($urandom(32'h5eed));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!ser_data_o && !ser_clk_o && !busy_o && out_word_o == 0, "R1 reset",
          {ser_data_o, ser_clk_o, busy_o, out_word_o[28:0]}, 32'd0);

    // R2 word write and hold across modes
    write_word(32'hCAFE_1234);
    check(out_word_o == 32'hCAFE_1234, "R2 write", out_word_o, 32'hCAFE_1234);
    mode_i = 2'b01; repeat (3) @(negedge clk);
    mode_i = 2'b10; repeat (3) @(negedge clk);
    check(out_word_o == 32'hCAFE_1234, "R2 hold", out_word_o, 32'hCAFE_1234);

    // R3 loads in non-serial mode; R4/R5 first drain; R7 drop enable mid-word
    mode_i = 2'b00;
    a = 32'hFFFF_A5C3; b = 32'h0000_1E0F;
    load_buf(a, 0);
    load_buf(b, 1);
    mode_i = 2'b01; buf_sel_i = 1'b0; shift_en_i = 1'b1;
    collect(1, got, started);
    check(started, "R7 start with enable", {31'd0, started}, 32'd1);
    check(got == expect_stream(a), "R3 R4 R5 buffer 0 stream", {16'd0, got}, {16'd0, expect_stream(a)});
    stay_idle(40, "R7 R10 no restart, pin at 0");
    // R6 selected empty, other fresh
    shift_en_i = 1'b1;
    collect(1, got, started);
    check(got == expect_stream(b), "R6 fallback to buffer 1", {16'd0, got}, {16'd0, expect_stream(b)});
    // R6 neither fresh: idle under enable
    shift_en_i = 1'b1;
    stay_idle(40, "R6 idle with both empty");
    shift_en_i = 1'b0;

    // R5 both fresh, select 1 first, then R6 back-to-back
    load_buf(32'h0000_8001, 0);
    load_buf(32'h0000_7FFE, 1);
    buf_sel_i = 1'b1; shift_en_i = 1'b1;
    collect(0, got, started);
    check(got == 16'h7FFE, "R5 selected buffer 1 first", {16'd0, got}, 32'h7FFE);
    collect(1, got, started);
    check(got == 16'h8001, "R6 then buffer 0", {16'd0, got}, 32'h8001);
    stay_idle(40, "R7 idle after drop");

    // R8 silent drain in non-serial mode
    mode_i = 2'b11;
    load_buf(32'h0000_FFFF, 0);
    buf_sel_i = 1'b0; shift_en_i = 1'b1;
    run = 0; silent = 1;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (busy_o) begin run++; shift_en_i = 1'b0; end
      if (ser_data_o || ser_clk_o) silent = 0;
    end
    check(silent, "R8 R9 pins quiet in non-serial mode", {31'd0, silent}, 32'd1);
    check(run == 32, "R8 R10 drain length", run, 32'd32);
    mode_i = 2'b01; shift_en_i = 1'b1;
    stay_idle(40, "R8 buffer was emptied");
    shift_en_i = 1'b0;

    // R9 clock runs without enable in serial mode
    toggling = 1;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      logic p;
      p = ser_clk_o;
      @(negedge clk);
      if (ser_clk_o == p) toggling = 0;
    end
    check(toggling, "R9 free-running clock", {31'd0, toggling}, 32'd1);
    mode_i = 2'b00; @(negedge clk);
    parked = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (ser_clk_o) parked = 0;
    end
    check(parked, "R9 clock parked", {31'd0, parked}, 32'd1);

    // random words, random buffer and mode during load
    for (int it = 0; it < 10; it++) begin
      logic [31:0] w;
      bit idx;
      w = $urandom;
      idx = 1'($urandom);
      mode_i = 2'($urandom);
      load_buf(w, idx);
      check(out_word_o == w, "R2 random word", out_word_o, w);
      mode_i = 2'b01; buf_sel_i = 1'($urandom); shift_en_i = 1'b1;
      collect(1, got, started);
      check(got == expect_stream(w), "R4 random stream", {16'd0, got}, {16'd0, expect_stream(w)});
      repeat (4) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule